// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block takes the error-check code computed over a 256-byte chunk of flash data, along with the code read back from flash for that chunk. It decides whether the chunk is clean, whether only the stored code was damaged, whether exactly one data bit flipped, or whether the damage cannot be repaired.

When one data bit flipped, the block reports which byte and which bit are wrong. It then repairs that byte in the attached data buffer with a single read-modify-write. The buffer is reached through a simple byte port that has one cycle of read latency.

A wide mode treats the buffer as two consecutive 256-byte chunks. Each chunk has its own code: the second chunk uses buffer offset 256 and code bytes 3 to 5. The two chunks are handled in order, and their failures are combined into one flag.

Top module: `hamming_fix_top`

## Requirements
- R1: Chunk h (0 or 1) takes its 22-bit code from bits [24h+21:24h] of `calc_code_i` / `stored_code_i`, so byte 3h is least significant. Bits 24h+22 and 24h+23 are ignored. Bits [10:0] of a code form its low half and bits [21:11] its high half.
- R2: If the XOR of the two codes (the syndrome) is zero, or if either code is all zeros, the chunk's result code is 0 (clean). No buffer access is made for that chunk.
- R3: Otherwise, if the syndrome has exactly one bit set, the result code is 1 (stored code damaged). This counts as a failure, and no buffer access is made.
- R4: Otherwise, the error is correctable if the syndrome has exactly 11 bits set and the following value is 0x7FF: (low half XOR high half of the computed code) XOR (low half XOR high half of the stored code). A correctable chunk gets result code 2, `err_byte` = syndrome[10:3] and `err_bit` = syndrome[2:0], and it does not count as a failure. For chunks that are not correctable, `err_byte` and `err_bit` read 0.
- R5: Every other syndrome gives result code 3 (uncorrectable), which counts as a failure.
- R6: For each chunk with result code 2, the block reads the buffer at address {h, err_byte}. It waits one cycle for the data, then writes back the same byte with bit `err_bit` inverted. This happens exactly once per chunk, chunk 0 first, and the read and write strobes are never high together.
- R7: With `wide_i` low, chunk 1 reports result code 0 with zero location, and the upper 256 bytes of the buffer are never accessed.
- R8: `fail_o` equals the OR of the failure indications of the evaluated chunks, that is, of bit 0 of each result code.
- R9: The result codes are registered at the second rising edge after `start_i` is sampled. `done_o` is a one-cycle pulse that follows the last buffer write. All results hold until the next accepted start.
- R10: A `start_i` that arrives before `done_o` of the current operation is ignored.
- R11: After synchronous reset, `done_o`, `fail_o`, `res_o`, `err_byte_o`, `err_bit_o` and both buffer strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| wide_i | input | 1 | 1 = two chunks (512 bytes), 0 = one chunk |
| calc_code_i | input | 48 | Computed codes, one 24-bit slot per chunk |
| stored_code_i | input | 48 | Codes read from flash, same layout |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | OR of chunk failures |
| res_o | output | 4 | Result code per chunk, chunk 0 in bits [1:0] |
| err_byte_o | output | 16 | Failing byte index per chunk, chunk 0 in bits [7:0] |
| err_bit_o | output | 6 | Failing bit per chunk, chunk 0 in bits [2:0] |
| mem_addr_o | output | 9 | Buffer byte address |
| mem_rd_o | output | 1 | Buffer read strobe; data on `mem_rdata_i` next cycle |
| mem_rdata_i | input | 8 | Buffer read data |
| mem_wr_o | output | 1 | Buffer write strobe |
| mem_wdata_o | output | 8 | Buffer write data |

## Verification
The hardest case to reach from the ports is a correctable error. It needs a syndrome of exactly eleven set bits whose two halves are exact complements, and random codes almost never produce one. The stimulus therefore builds the error pattern as a chosen 11-bit location next to its bitwise complement and XORs it onto a random computed code. Single-bit patterns, zero codes and free random patterns are mixed in the same way. Directed cases cover the location extremes (byte 255 bit 7, byte 0 bit 0), both chunks repairing in one operation, and a second start arriving mid-operation.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  // Per-chunk verdict; bit 0 set means the chunk counts as a failure.
  typedef enum logic [1:0] {
    RES_CLEAN   = 2'd0,
    RES_ECC_BAD = 2'd1,
    RES_FIXED   = 2'd2,
    RES_UNCORR  = 2'd3
  } fix_res_e;

endpackage

// File: rtl/syn_classify.sv
module syn_classify
  import ecc_fix_pkg::*;
#(
  parameter int HALF_W = 11,
  parameter int BIT_W  = 3
) (
  input  logic [2*HALF_W-1:0]      calc_i,
  input  logic [2*HALF_W-1:0]      stored_i,
  output fix_res_e                 res_o,
  output logic [HALF_W-BIT_W-1:0]  idx_o,
  output logic [BIT_W-1:0]         bit_o
);
  localparam int CODE_W = 2 * HALF_W;
  localparam int IDX_W  = HALF_W - BIT_W;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] syn;
  logic [HALF_W-1:0] fold;
  logic [CNT_W-1:0]  ones;

  always_comb begin
    syn  = calc_i ^ stored_i;
    fold = calc_i[HALF_W-1:0] ^ calc_i[CODE_W-1:HALF_W]
         ^ stored_i[HALF_W-1:0] ^ stored_i[CODE_W-1:HALF_W];
    ones = '0;
    for (int i = 0; i < CODE_W; i++) begin
      ones = ones + CNT_W'(syn[i]);
    end
    idx_o = syn[BIT_W +: IDX_W];
    bit_o = syn[BIT_W-1:0];
    if (syn == '0 || calc_i == '0 || stored_i == '0) begin
      res_o = RES_CLEAN;
    end else if (ones == CNT_W'(1)) begin
      res_o = RES_ECC_BAD;
    end else if (ones == CNT_W'(HALF_W) && fold == {HALF_W{1'b1}}) begin
      res_o = RES_FIXED;
    end else begin
      res_o = RES_UNCORR;
    end
  end

endmodule

// File: rtl/rmw_patcher.sv
module rmw_patcher #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [$clog2(DATA_W)-1:0] bit_i,
  input  logic [DATA_W-1:0]         rdata_i,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic                      mem_rd_o,
  output logic                      mem_wr_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  output logic                      done_o
);
  typedef enum logic [1:0] {P_IDLE, P_RD, P_WAIT, P_WR} pst_e;

  pst_e              st_q;
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= P_IDLE;
      mem_addr_o  <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_wdata_o <= '0;
      mask_q      <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (go_i) begin
          mem_addr_o <= addr_i;
          mask_q     <= DATA_W'(1) << bit_i;
          mem_rd_o   <= 1'b1;
          st_q       <= P_RD;
        end
        P_RD: begin
          mem_rd_o <= 1'b0;
          st_q     <= P_WAIT;
        end
        P_WAIT: begin
          mem_wr_o    <= 1'b1;
          mem_wdata_o <= rdata_i ^ mask_q;
          st_q        <= P_WR;
        end
        default: begin
          mem_wr_o <= 1'b0;
          st_q     <= P_IDLE;
        end
      endcase
    end
  end

  assign done_o = (st_q == P_WR);

endmodule

// File: rtl/hamming_fix_top.sv
module hamming_fix_top
  import ecc_fix_pkg::*;
#(
  parameter int HALF_W = 11,
  parameter int DATA_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   start_i,
  input  logic                                   wide_i,
  input  logic [2*((2*HALF_W+7)/8)*8-1:0]        calc_code_i,
  input  logic [2*((2*HALF_W+7)/8)*8-1:0]        stored_code_i,
  output logic                                   done_o,
  output logic                                   fail_o,
  output logic [3:0]                             res_o,
  output logic [2*(HALF_W-$clog2(DATA_W))-1:0]   err_byte_o,
  output logic [2*$clog2(DATA_W)-1:0]            err_bit_o,
  output logic [HALF_W-$clog2(DATA_W):0]         mem_addr_o,
  output logic                                   mem_rd_o,
  input  logic [DATA_W-1:0]                      mem_rdata_i,
  output logic                                   mem_wr_o,
  output logic [DATA_W-1:0]                      mem_wdata_o
);
  localparam int NHALF  = 2;
  localparam int HSEL_W = $clog2(NHALF);
  localparam int CODE_W = 2 * HALF_W;
  localparam int SLOT_W = ((CODE_W + 7) / 8) * 8;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int IDX_W  = HALF_W - BIT_W;
  localparam int ADDR_W = IDX_W + HSEL_W;

  typedef enum logic [2:0] {T_IDLE, T_CLASS, T_SCAN, T_PATCH, T_DONE} tst_e;

  tst_e                          st_q;
  logic [HSEL_W-1:0]             half_q;
  logic                          wide_q;
  logic [NHALF-1:0][CODE_W-1:0]  calc_q;
  logic [NHALF-1:0][CODE_W-1:0]  stored_q;
  logic [NHALF-1:0][1:0]         res_q;
  logic [NHALF-1:0][IDX_W-1:0]   idx_q;
  logic [NHALF-1:0][BIT_W-1:0]   bit_q;
  logic                          fail_q;

  fix_res_e                      cls_res [NHALF];
  logic [IDX_W-1:0]              cls_idx [NHALF];
  logic [BIT_W-1:0]              cls_bit [NHALF];
  logic [NHALF-1:0][1:0]         sel_res;
  logic [NHALF-1:0][IDX_W-1:0]   sel_idx;
  logic [NHALF-1:0][BIT_W-1:0]   sel_bit;
  logic                          sel_fail;

  logic                          patch_go;
  logic                          patch_done;
  logic                          last_half;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    syn_classify #(.HALF_W(HALF_W), .BIT_W(BIT_W)) u_cls (
      .calc_i   (calc_q[g]),
      .stored_i (stored_q[g]),
      .res_o    (cls_res[g]),
      .idx_o    (cls_idx[g]),
      .bit_o    (cls_bit[g])
    );

    always_comb begin
      if (g == 0 || wide_q) begin
        sel_res[g] = cls_res[g];
      end else begin
        sel_res[g] = RES_CLEAN;
      end
      if (sel_res[g] == RES_FIXED) begin
        sel_idx[g] = cls_idx[g];
        sel_bit[g] = cls_bit[g];
      end else begin
        sel_idx[g] = '0;
        sel_bit[g] = '0;
      end
    end
  end

  always_comb begin
    sel_fail = 1'b0;
    for (int h = 0; h < NHALF; h++) begin
      sel_fail = sel_fail | sel_res[h][0];
    end
  end

  assign last_half = (int'(half_q) == NHALF - 1);
  assign patch_go  = (st_q == T_SCAN) && (res_q[half_q] == RES_FIXED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= T_IDLE;
      half_q   <= '0;
      wide_q   <= 1'b0;
      calc_q   <= '0;
      stored_q <= '0;
      res_q    <= '0;
      idx_q    <= '0;
      bit_q    <= '0;
      fail_q   <= 1'b0;
    end else begin
      case (st_q)
        T_IDLE: if (start_i) begin
          for (int h = 0; h < NHALF; h++) begin
            calc_q[h]   <= calc_code_i[h*SLOT_W +: CODE_W];
            stored_q[h] <= stored_code_i[h*SLOT_W +: CODE_W];
          end
          wide_q <= wide_i;
          st_q   <= T_CLASS;
        end
        T_CLASS: begin
          res_q  <= sel_res;
          idx_q  <= sel_idx;
          bit_q  <= sel_bit;
          fail_q <= sel_fail;
          half_q <= '0;
          st_q   <= T_SCAN;
        end
        T_SCAN: begin
          if (patch_go) begin
            st_q <= T_PATCH;
          end else if (last_half) begin
            st_q <= T_DONE;
          end else begin
            half_q <= half_q + HSEL_W'(1);
          end
        end
        T_PATCH: if (patch_done) begin
          if (last_half) begin
            st_q <= T_DONE;
          end else begin
            half_q <= half_q + HSEL_W'(1);
            st_q   <= T_SCAN;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  rmw_patcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_patch (
    .clk         (clk),
    .rst         (rst),
    .go_i        (patch_go),
    .addr_i      ({half_q, idx_q[half_q]}),
    .bit_i       (bit_q[half_q]),
    .rdata_i     (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (patch_done)
  );

  assign done_o     = (st_q == T_DONE);
  assign fail_o     = fail_q;
  assign res_o      = res_q;
  assign err_byte_o = idx_q;
  assign err_bit_o  = bit_q;

endmodule

// File: rtl/hamming_fix_checker.sv
module hamming_fix_checker #(
  parameter int HALF_W = 11,
  parameter int DATA_W = 8
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 done_o,
  input logic                                 fail_o,
  input logic [3:0]                           res_o,
  input logic [2*(HALF_W-$clog2(DATA_W))-1:0] err_byte_o,
  input logic [HALF_W-$clog2(DATA_W):0]       mem_addr_o,
  input logic                                 mem_rd_o,
  input logic [DATA_W-1:0]                    mem_rdata_i,
  input logic                                 mem_wr_o,
  input logic [DATA_W-1:0]                    mem_wdata_o
);
  localparam int IDX_W = HALF_W - $clog2(DATA_W);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> ($past(mem_rd_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));

  assert_one_bit_flip_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> $countones(mem_wdata_o ^ $past(mem_rdata_i)) == 1);

  assert_access_needs_fix_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> (res_o[1:0] == 2'd2 || res_o[3:2] == 2'd2));

  assert_fix_location_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> mem_addr_o[IDX_W-1:0] ==
      (mem_addr_o[IDX_W] ? err_byte_o[2*IDX_W-1:IDX_W] : err_byte_o[IDX_W-1:0]));

  assert_fail_or_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> fail_o == (res_o[0] | res_o[2]));

endmodule

bind hamming_fix_top hamming_fix_checker #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .res_o       (res_o),
  .err_byte_o  (err_byte_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_rdata_i (mem_rdata_i),
  .mem_wr_o    (mem_wr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/hamming_fix_top_test.sv
module hamming_fix_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [47:0] calc_code_i = '0;
  logic [47:0] stored_code_i = '0;
  logic        done_o, fail_o, mem_rd_o, mem_wr_o;
  logic [3:0]  res_o;
  logic [15:0] err_byte_o;
  logic [5:0]  err_bit_o;
  logic [8:0]  mem_addr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [7:0]  mem_wdata_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int rd_cnt = 0;
  logic [7:0] mem  [512];
  logic [7:0] gold [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_fix_top uut (
    .clk(clk), .rst(rst), .start_i(start_i), .wide_i(wide_i),
    .calc_code_i(calc_code_i), .stored_code_i(stored_code_i),
    .done_o(done_o), .fail_o(fail_o), .res_o(res_o),
    .err_byte_o(err_byte_o), .err_bit_o(err_bit_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rd_o) begin
      mem_rdata_i <= mem[mem_addr_o];
      rd_cnt      <= rd_cnt + 1;
    end
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected verdict for one chunk, from the requirements.
  task automatic classify(input logic [21:0] c, input logic [21:0] s,
                          output logic [1:0] r, output logic [7:0] by,
                          output logic [2:0] bi);
    logic [21:0] e;
    logic [10:0] f;
    e  = c ^ s;
    f  = c[10:0] ^ c[21:11] ^ s[10:0] ^ s[21:11];
    by = 8'd0;
    bi = 3'd0;
    if (e == 0 || c == 0 || s == 0) r = 2'd0;
    else if ($countones(e) == 1) r = 2'd1;
    else if ($countones(e) == 11 && f == 11'h7FF) begin
      r  = 2'd2;
      by = e[10:3];
      bi = e[2:0];
    end else r = 2'd3;
  endtask

  task automatic op(input logic w, input logic [47:0] c, input logic [47:0] s,
                    input bit poke);
    logic [1:0] er [2];
    logic [7:0] eb [2];
    logic [2:0] ei [2];
    logic       efail;
    int         nfix, bad, waited;
    efail = 1'b0;
    nfix  = 0;
    for (int h = 0; h < 2; h++) begin
      classify(c[24*h +: 22], s[24*h +: 22], er[h], eb[h], ei[h]);
      if (h == 1 && !w) begin
        er[h] = 2'd0; eb[h] = 8'd0; ei[h] = 3'd0;
      end
      efail = efail | er[h][0];
      if (er[h] == 2'd2) begin
        nfix++;
        gold[{h[0], eb[h]}] = gold[{h[0], eb[h]}] ^ (8'd1 << ei[h]);
      end
    end
    rd_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; wide_i = w; calc_code_i = c; stored_code_i = s;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(res_o == {er[1], er[0]}, "R9", "result two edges after start",
        res_o, {er[1], er[0]});
    if (poke) begin
      start_i = 1'b1; calc_code_i = ~c; stored_code_i = c;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (!done_o && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    chk(done_o, "R9", "done reached", done_o, 1);
    chk(res_o[1:0] == er[0], "R2 R3 R4 R5", "chunk0 result", res_o[1:0], er[0]);
    chk(res_o[3:2] == er[1], "R7", "chunk1 result", res_o[3:2], er[1]);
    chk(err_byte_o == {eb[1], eb[0]} && err_bit_o == {ei[1], ei[0]}, "R4",
        "location", {err_byte_o, err_bit_o}, {eb[1], eb[0], ei[1], ei[0]});
    chk(fail_o == efail, "R8", "fail flag", fail_o, efail);
    @(negedge clk);
    chk(!done_o, "R9", "done one cycle", done_o, 0);
    chk(rd_cnt == nfix, "R6 R10", "buffer read count", rd_cnt, nfix);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== gold[i]) bad++;
    chk(bad == 0, "R6 R7", "buffer contents mismatches", bad, 0);
  endtask

  function automatic logic [21:0] fix_pat(input logic [10:0] v);
    return {~v, v};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin
      mem[i]  = 8'($urandom);
      gold[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({done_o, fail_o, res_o, err_byte_o, err_bit_o, mem_rd_o, mem_wr_o} == 0,
        "R11", "reset state",
        {done_o, fail_o, res_o, err_byte_o, err_bit_o, mem_rd_o, mem_wr_o}, 0);

    // R2: clean, and computed code all zero
    op(1'b1, {24'h0_12345, 24'h0_1ABCD}, {24'h0_12345, 24'h0_1ABCD}, 1'b0);
    op(1'b1, {24'h0_00000, 24'h0_1ABCD}, {24'h0_00777, 24'h0_1ABCD}, 1'b0);
    // R3: one-bit syndrome
    op(1'b0, {24'h0, 24'h0_2F00F}, {24'h0, 24'h0_2F00F ^ 24'h020000}, 1'b0);
    // R4: extreme locations, both chunks repaired, plus mid-operation start (R10)
    op(1'b1, {24'h0_15A5A, 24'h0_33CC3},
       {24'h0_15A5A ^ {2'b0, fix_pat(11'h000)}, 24'h0_33CC3 ^ {2'b0, fix_pat(11'h7FF)}}, 1'b1);
    // R1: junk in the unused top bits of each slot
    op(1'b1, {24'hC0_1234, 24'h80_2222},
       {24'h40_1234 ^ {2'b0, fix_pat(11'h155)}, 24'hC0_2222}, 1'b0);
    // R7: narrow mode ignores a repairable chunk 1
    op(1'b0, {24'h0_0F0F0, 24'h0_11111},
       {24'h0_0F0F0 ^ {2'b0, fix_pat(11'h0AB)}, 24'h0_11111 ^ {2'b0, fix_pat(11'h3C1)}}, 1'b0);
    // R5: uncorrectable two-bit syndrome
    op(1'b1, {24'h0, 24'h0_3FFFF}, {24'h0, 24'h0_3FFFF ^ 24'h000011}, 1'b1);

    for (int n = 0; n < 250; n++) begin
      logic [47:0] c, s;
      logic [21:0] ch, e;
      for (int h = 0; h < 2; h++) begin
        ch = 22'($urandom);
        if ($urandom % 16 == 0) ch = '0;
        case ($urandom % 4)
          0: e = '0;
          1: e = 22'd1 << ($urandom % 22);
          2: e = fix_pat(11'($urandom));
          default: e = 22'($urandom);
        endcase
        c[24*h +: 24] = {2'($urandom), ch};
        s[24*h +: 24] = {2'($urandom), ch ^ e};
      end
      op(1'($urandom), c, s, ($urandom % 8) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired: actual=%0d expected<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule